// File: doc/BRIEF.md
# Synchronous Slave-Parallel Configuration Loader

This block is the front end that loads configuration data into a programmable device. A free-running external load clock drives it, and a host presents configuration bytes on a parallel bus. While the three mode inputs hold the synchronous-parallel code, the block takes one byte and then another on every eighth rising edge after it. It turns each byte into a serial stream, most significant bit first, at one bit per rising edge. After each byte it raises an acknowledge for one cycle.

The serial stream is split by position. A leading header of `PRE_BITS` bits goes to the serial chain output. The next `FRAME_BITS` bits are this device's own frame and leave on the internal configuration stream. Every bit after that overflows to the chain output for the devices further down the chain. The chain output is re-timed onto the falling edge, 1.5 periods after the capturing edge, so the next device can sample it on the following rising edge. A status output rises once the own frame is full and `FLUSH_EDGES` further rising edges have passed.

Top module: `slp_loader`

## Requirements
- R1: When `mode_i` becomes 3'b011, the block captures `data_i` on the first rising edge. It captures again on every eighth consecutive rising edge for as long as the mode code holds.
- R2: A captured byte is emitted on `cfg_bit_o` one bit per rising edge, starting with bit 7, in the eight cycles after its capture edge. `cfg_vld_o` is high only for stream positions `PRE_BITS` to `PRE_BITS+FRAME_BITS-1`, counted from 0. `cfg_bit_o` is 0 whenever `cfg_vld_o` is low.
- R3: `ack_o` is high for exactly the one clock period that follows each capture edge.
- R4: Stream positions below `PRE_BITS`, and positions at or above `PRE_BITS+FRAME_BITS`, appear on `dout_o`. While an own-frame bit is being consumed, `dout_o` carries logic 1.
- R5: `dout_o` changes only on falling edges. A bit that is first visible in the cycle after its capture edge appears on `dout_o` at the next falling edge, 1.5 periods after that capture edge. When no bit is forwarded, `dout_o` idles at 1.
- R6: For any `mode_i` other than 3'b011, `ack_o` and `cfg_vld_o` are 0 and `dout_o` is 1. Any partly shifted byte is dropped, and byte timing restarts when the code returns.
- R7: `done_o` rises `FLUSH_EDGES` rising edges after the edge that consumes the last own-frame bit. It then stays high until reset.
- R8: A low `rst_n` at a rising edge clears the byte phase, the shift register, the stream position and the flush count. `ack_o`, `cfg_vld_o` and `done_o` are then low and `dout_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cclk | input | 1 | Load clock; captures and shifts on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 3 | Mode select; the block is active only at 3'b011 |
| data_i | input | DATA_W | Parallel configuration byte |
| ack_o | output | 1 | One-cycle acknowledge after each capture |
| cfg_bit_o | output | 1 | Own-frame serial configuration bit |
| cfg_vld_o | output | 1 | Qualifies `cfg_bit_o` |
| dout_o | output | 1 | Serial chain output, updated on falling edges, idle high |
| done_o | output | 1 | Own frame complete and flush edges elapsed |

## Verification
Two things land on the same rising edge. The edge that captures a new byte also consumes the last bit of the previous byte, and in the same cycle the acknowledge rises while that bit is still being routed to the chain output or the own stream. The bench sends bytes back to back with no gap, so this overlap happens on every eighth edge. It also drops the mode code for single cycles at several byte phases, and forces a reset in the middle of a byte. A queue-based model of the bit stream predicts `ack_o`, `cfg_bit_o`, `cfg_vld_o`, `dout_o` and `done_o`, and the bench compares all five to the model in every cycle.

// File: rtl/slp_pkg.sv
package slp_pkg;
  localparam logic [2:0] SLP_ACTIVE_CODE = 3'b011;

  // true when the stream position belongs to this device's own frame
  function automatic logic pos_is_own(input int unsigned pos, input int unsigned pre_bits,
                                      input int unsigned frame_bits);
    return (pos >= pre_bits) && (pos < pre_bits + frame_bits);
  endfunction

  // position after one more consumed bit, saturating at the frame end
  function automatic int unsigned pos_advance(input int unsigned pos, input int unsigned limit);
    return (pos < limit) ? pos + 1 : limit;
  endfunction
endpackage

// File: rtl/slp_byte_sequencer.sv
module slp_byte_sequencer #(
  parameter int DATA_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  output logic capture,
  output logic ack_q
);
  localparam int PH_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  logic [PH_W-1:0] phase;

  assign capture = active && (phase == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= '0;
      ack_q <= 1'b0;
    end else begin
      ack_q <= capture;
      if (!active) phase <= '0;
      else         phase <= (int'(phase) == DATA_W-1) ? '0 : phase + PH_W'(1);
    end
  end
endmodule

// File: rtl/slp_serializer.sv
module slp_serializer #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              capture,
  input  logic [DATA_W-1:0] data,
  output logic              cur_bit,
  output logic              loaded
);
  logic [DATA_W-1:0] sreg;

  assign cur_bit = sreg[DATA_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sreg   <= '0;
      loaded <= 1'b0;
    end else if (!active) begin
      loaded <= 1'b0;
    end else if (capture) begin
      sreg   <= data;
      loaded <= 1'b1;
    end else if (loaded) begin
      sreg <= {sreg[DATA_W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/slp_frame_router.sv
module slp_frame_router
  import slp_pkg::*;
#(
  parameter int PRE_BITS    = 8,
  parameter int FRAME_BITS  = 32,
  parameter int FLUSH_EDGES = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic consume,
  output logic own_now,
  output logic fwd_now,
  output logic done
);
  localparam int LIMIT = PRE_BITS + FRAME_BITS;
  localparam int POS_W = $clog2(LIMIT + 1);
  localparam int FL_W  = $clog2(FLUSH_EDGES + 1) + 1;

  logic [POS_W-1:0] pos;
  logic [FL_W-1:0]  flush_cnt;
  logic             pos_own;

  assign pos_own = pos_is_own(int'(pos), PRE_BITS, FRAME_BITS);
  assign own_now = consume && pos_own;
  assign fwd_now = consume && !pos_own;
  assign done    = (int'(flush_cnt) == FLUSH_EDGES);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos       <= '0;
      flush_cnt <= '0;
    end else begin
      if ((int'(pos) == LIMIT) && !done) flush_cnt <= flush_cnt + FL_W'(1);
      if (consume) pos <= POS_W'(pos_advance(int'(pos), LIMIT));
    end
  end
endmodule

// File: rtl/slp_dout_retimer.sv
module slp_dout_retimer (
  input  logic clk,
  input  logic rst_n,
  input  logic fwd,
  input  logic bit_in,
  output logic fwd_q,
  output logic dout_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) fwd_q <= 1'b1;
    else        fwd_q <= fwd ? bit_in : 1'b1;
  end

  always_ff @(negedge clk) begin
    if (!rst_n) dout_q <= 1'b1;
    else        dout_q <= fwd_q;
  end
endmodule

// File: rtl/slp_loader.sv
module slp_loader
  import slp_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int PRE_BITS    = 8,
  parameter int FRAME_BITS  = 32,
  parameter int FLUSH_EDGES = 10
) (
  input  logic              cclk,
  input  logic              rst_n,
  input  logic [2:0]        mode_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              ack_o,
  output logic              cfg_bit_o,
  output logic              cfg_vld_o,
  output logic              dout_o,
  output logic              done_o
);
  logic active;
  logic cap_evt;
  logic ack_q;
  logic cur_bit;
  logic loaded;
  logic consume;
  logic own_now;
  logic fwd_now;
  logic fwd_q;
  logic dout_q;

  assign active  = (mode_i == SLP_ACTIVE_CODE);
  assign consume = active && loaded;

  slp_byte_sequencer #(.DATA_W(DATA_W)) u_seq (
    .clk(cclk), .rst_n(rst_n), .active(active), .capture(cap_evt), .ack_q(ack_q)
  );

  slp_serializer #(.DATA_W(DATA_W)) u_ser (
    .clk(cclk), .rst_n(rst_n), .active(active), .capture(cap_evt), .data(data_i),
    .cur_bit(cur_bit), .loaded(loaded)
  );

  slp_frame_router #(
    .PRE_BITS(PRE_BITS), .FRAME_BITS(FRAME_BITS), .FLUSH_EDGES(FLUSH_EDGES)
  ) u_route (
    .clk(cclk), .rst_n(rst_n), .consume(consume),
    .own_now(own_now), .fwd_now(fwd_now), .done(done_o)
  );

  slp_dout_retimer u_rt (
    .clk(cclk), .rst_n(rst_n), .fwd(fwd_now), .bit_in(cur_bit),
    .fwd_q(fwd_q), .dout_q(dout_q)
  );

  assign ack_o     = ack_q && active;
  assign cfg_vld_o = own_now;
  assign cfg_bit_o = own_now && cur_bit;
  assign dout_o    = active ? dout_q : 1'b1;
endmodule

// File: rtl/slp_loader_chk.sv
module slp_loader_chk #(
  parameter int DATA_W = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] mode,
  input logic       ack,
  input logic       dout,
  input logic       cfg_vld,
  input logic       done,
  input logic       cap_evt,
  input logic       fwd_q
);
  logic       seen;
  logic [7:0] gap;
  logic       act;

  assign act = (mode == 3'b011);

  always_ff @(posedge clk) begin
    if (!rst_n || !act) begin
      seen <= 1'b0;
      gap  <= '0;
    end else if (cap_evt) begin
      seen <= 1'b1;
      gap  <= '0;
    end else begin
      gap <= gap + 8'd1;
    end
  end

  assert_byte_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_evt && seen) |-> (int'(gap) == DATA_W-1));

  assert_ack_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  assert_ack_after_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (ack || !act));

  assert_own_not_forwarded_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_vld |=> fwd_q);

  assert_idle_outputs_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !act |-> (dout && !ack && !cfg_vld));

  assert_done_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

  assert_reset_clears_R8: assert property (@(posedge clk)
    !rst_n |=> (!done && !ack));
endmodule

bind slp_loader slp_loader_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(cclk), .rst_n(rst_n), .mode(mode_i), .ack(ack_o), .dout(dout_o),
  .cfg_vld(cfg_vld_o), .done(done_o), .cap_evt(cap_evt), .fwd_q(fwd_q)
);

// File: tb/sim_slp_loader.sv
`timescale 1ns/1ps
module sim_slp_loader;
  localparam int HDR   = 8;
  localparam int OWN   = 32;
  localparam int TAILN = 10;
  localparam int END_P = HDR + OWN;

  logic       cclk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] mode_i = 3'b011;
  logic [7:0] data_i = 8'h00;
  logic ack_o, cfg_bit_o, cfg_vld_o, dout_o, done_o;

  int compared = 0;
  int mismatched = 0;
  int armed = 0;

  always #2.5 cclk = ~cclk;

  slp_loader u0 (
    .cclk(cclk), .rst_n(rst_n), .mode_i(mode_i), .data_i(data_i),
    .ack_o(ack_o), .cfg_bit_o(cfg_bit_o), .cfg_vld_o(cfg_vld_o),
    .dout_o(dout_o), .done_o(done_o)
  );

  // behavioural reference: pending stream bits held in a queue
  int m_q[$];
  int m_ph = 0, m_pos = 0, m_fl = 0, m_fq = 1;
  bit m_cap = 0;

  always @(posedge cclk) begin
    bit act;
    int b;
    act = (mode_i == 3'b011);
    if (!rst_n) begin
      m_q.delete(); m_ph = 0; m_pos = 0; m_fl = 0; m_fq = 1; m_cap = 0;
    end else begin
      if (m_pos == END_P && m_fl < TAILN) m_fl++;
      if (act && m_q.size() > 0) begin
        b = m_q.pop_front();
        m_fq = (m_pos >= HDR && m_pos < END_P) ? 1 : b;
        if (m_pos < END_P) m_pos++;
      end else m_fq = 1;
      if (!act) begin
        m_q.delete(); m_ph = 0; m_cap = 0;
      end else begin
        m_cap = (m_ph == 0);
        if (m_cap) for (int i = 7; i >= 0; i--) m_q.push_back(int'(data_i[i]));
        m_ph = (m_ph + 1) % 8;
      end
    end
  end

  task automatic cmp(input string tag, input int act_v, input int exp_v);
    compared++;
    if (act_v != exp_v) begin
      mismatched++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, act_v, exp_v);
    end
  endtask

  task automatic compare_all();
    bit act;
    int e_vld, e_bit;
    act = (mode_i == 3'b011);
    e_vld = (act && m_q.size() > 0 && m_pos >= HDR && m_pos < END_P) ? 1 : 0;
    e_bit = e_vld ? m_q[0] : 0;
    cmp("R3 ack_o (R1 capture timing)", int'(ack_o), (m_cap && act) ? 1 : 0);
    cmp("R2 cfg_vld_o", int'(cfg_vld_o), e_vld);
    cmp("R2 cfg_bit_o", int'(cfg_bit_o), e_bit);
    cmp("R4/R5 dout_o", int'(dout_o), act ? m_fq : 1);
    cmp("R7 done_o", int'(done_o), (m_fl == TAILN) ? 1 : 0);
  endtask

  int seed = 17;
  task automatic cyc(input logic [2:0] m, input logic rn);
    @(negedge cclk);
    #0.5;
    mode_i = m;
    rst_n  = rn;
    seed   = (seed * 73 + 41) % 251;
    data_i = 8'(seed);
    #1.5;
    if (armed > 0) compare_all();
    armed++;
  endtask

  initial begin
    // R8: reset state with the mode code already active
    repeat (4) cyc(3'b011, 1'b0);
    // R1 R2 R3 R4 R5 R7: continuous bytes through header, own frame and overflow
    repeat (72) cyc(3'b011, 1'b1);
    // R6: foreign mode codes, then re-entry restarts byte timing
    repeat (5) cyc(3'b000, 1'b1);
    repeat (19) cyc(3'b011, 1'b1);
    cyc(3'b111, 1'b1);
    repeat (13) cyc(3'b011, 1'b1);
    cyc(3'b010, 1'b1);
    repeat (10) cyc(3'b011, 1'b1);
    // R8: reset in the middle of a byte, then a full run with a one-cycle drop
    repeat (2) cyc(3'b011, 1'b0);
    repeat (29) cyc(3'b011, 1'b1);
    cyc(3'b001, 1'b1);
    repeat (70) cyc(3'b011, 1'b1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #20000;
    mismatched++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule